// File: doc/BRIEF.md
# Quadrature Count-Pulse Converter

The block takes the two phase signals of an incremental encoder and turns each accepted phase edge into one active-low count pulse for a downstream up/down counter. Each phase is synchronized and then passed through a stability filter whose length is set in system clocks. The filtered edges are decoded at one of three resolutions, and a programmable timer sets how long each pulse stays low.

The output pins have two styles. In split style, the first line carries up pulses and the second line carries down pulses. In combined style, the first line carries every count and the second line is a direction level. While a pulse is low, new phase changes are not evaluated, so encoder dither at an edge cannot produce extra counts. If both phases change in the same filtered step, that step is flagged as an error and produces no pulse.

Top module: `quad_pulse_conv`

## Requirements
- R1: While rst_ni is low, ch0_no and ch1_o are high and err_o is low, in both styles.
- R2: With mode_i = 2'b10, every filtered edge of A or B gives one pulse. Forward motion gives up pulses only. Forward means A leads B, with (A,B) stepping 00, 10, 11, 01.
- R3: Reverse motion (A lags B) gives down pulses only. With mode_i = 2'b11 the block also runs at x4, so 8 reverse steps give 8 down pulses.
- R4: With mode_i = 2'b01, only A edges count: 2 pulses per quadrature cycle.
- R5: With mode_i = 2'b00, one pulse per cycle. A rising while B is low counts up. A falling while B is low counts down.
- R6: Each pulse stays low for exactly pulse_width_i clocks. A width of 0 is treated as 1.
- R7: A change on an input shorter than filt_len_i clocks after synchronization is rejected and produces no pulse.
- R8: Phase changes that occur while a pulse is low, and that revert before it ends, produce no pulse.
- R9: With style_i = 1, every count is a low pulse on ch0_no. ch1_o is 1 for up and 0 for down. ch1_o is set when the pulse starts and stays stable through the pulse's rising edge.
- R10: A filtered step where A and B change together raises err_o for one clock and produces no pulse. Counting resumes from the new state.
- R11: The first filtered state after reset is taken as a reference only and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 1 | Encoder phase A |
| b_i | input | 1 | Encoder phase B |
| mode_i | input | 2 | Resolution: 00 x1, 01 x2, 1x x4 |
| style_i | input | 1 | 0 split lines, 1 clock plus direction |
| filt_len_i | input | FILT_W | Clocks a change must hold to be accepted |
| pulse_width_i | input | PW_W | Pulse low time in clocks |
| ch0_no | output | 1 | Up pulses (split) or count clock (combined), active low |
| ch1_o | output | 1 | Down pulses, active low (split), or direction level (combined) |
| err_o | output | 1 | One-clock flag for a simultaneous A/B change |

## Verification
The main function is driven with forward and reverse quadrature sequences at each of the four mode codes. The pulse counts separate x1, x2 and x4 decoding and expose any direction swap. Three further patterns are used:
- A two-clock glitch on A, which tells the filter threshold apart from plain synchronization.
- A B excursion inside a long pulse that returns before the pulse ends, which would add an up and a down count if the inhibit were missing.
- A double-phase step, which separates the error path from a normal count.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  typedef enum logic [1:0] {
    RES_X1 = 2'b00,
    RES_X2 = 2'b01,
    RES_X4 = 2'b10
  } res_e;

  function automatic res_e decode_res(input logic [1:0] code);
    return code[1] ? RES_X4 : res_e'(code);
  endfunction
endpackage

// File: rtl/qpc_filter.sv
module qpc_filter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             raw_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             filt_o,
  output logic             vld_o
);
  localparam int EXT_W = CNT_W + 1;

  logic             s0_q, s1_q;
  logic [CNT_W-1:0] cnt_q;
  logic [EXT_W-1:0] nxt, lim;

  assign lim = (len_i == '0) ? EXT_W'(1) : EXT_W'(len_i);
  assign nxt = EXT_W'(cnt_q) + EXT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_q   <= 1'b0;
      s1_q   <= 1'b0;
      cnt_q  <= '0;
      filt_o <= 1'b0;
      vld_o  <= 1'b0;
    end else begin
      s0_q <= raw_i;
      s1_q <= s0_q;
      if (vld_o && (s1_q == filt_o)) begin
        cnt_q <= '0;
      end else if (nxt >= lim) begin
        filt_o <= s1_q;
        vld_o  <= 1'b1;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/qpc_decode.sv
module qpc_decode
  import qpc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       a_i,
  input  logic       b_i,
  input  logic       vld_i,
  input  logic       busy_i,
  input  logic [1:0] mode_i,
  output logic       evt_o,
  output logic       up_o,
  output logic       err_o
);
  logic pa_q, pb_q, ref_q;
  logic chg_a, chg_b, live, count_ok;

  assign chg_a = a_i ^ pa_q;
  assign chg_b = b_i ^ pb_q;
  assign live  = vld_i && ref_q && !busy_i;
  // up when A leads B
  assign up_o  = chg_a ? (a_i ^ b_i) : ~(a_i ^ b_i);

  always_comb begin
    unique case (decode_res(mode_i))
      RES_X1:  count_ok = chg_a && !b_i;
      RES_X2:  count_ok = chg_a;
      default: count_ok = 1'b1;
    endcase
  end

  assign evt_o = live && (chg_a ^ chg_b) && count_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pa_q  <= 1'b0;
      pb_q  <= 1'b0;
      ref_q <= 1'b0;
      err_o <= 1'b0;
    end else begin
      err_o <= live && chg_a && chg_b;
      if (vld_i && !busy_i) begin
        pa_q  <= a_i;
        pb_q  <= b_i;
        ref_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/qpc_pulse.sv
module qpc_pulse #(
  parameter int PW_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            evt_i,
  input  logic            up_i,
  input  logic [PW_W-1:0] width_i,
  input  logic            style_i,
  output logic            busy_o,
  output logic            ch0_no,
  output logic            ch1_o
);
  logic [PW_W-1:0] cnt_q, w_eff;
  logic            act_q, dir_q;

  assign w_eff = (width_i == '0) ? PW_W'(1) : width_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      dir_q <= 1'b1;
      cnt_q <= '0;
    end else if (act_q) begin
      if (cnt_q == '0) act_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end else if (evt_i) begin
      act_q <= 1'b1;
      dir_q <= up_i;
      cnt_q <= w_eff - 1'b1;
    end
  end

  assign busy_o = act_q;
  assign ch0_no = style_i ? !act_q : !(act_q && dir_q);
  assign ch1_o  = style_i ? dir_q  : !(act_q && !dir_q);
endmodule

// File: rtl/quad_pulse_conv.sv
module quad_pulse_conv #(
  parameter int FILT_W = 8,
  parameter int PW_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_i,
  input  logic              b_i,
  input  logic [1:0]        mode_i,
  input  logic              style_i,
  input  logic [FILT_W-1:0] filt_len_i,
  input  logic [PW_W-1:0]   pulse_width_i,
  output logic              ch0_no,
  output logic              ch1_o,
  output logic              err_o
);
  localparam int NPH = 2;

  logic [NPH-1:0] raw, filt, vld;
  logic           evt, up, busy;

  assign raw = {b_i, a_i};

  for (genvar i = 0; i < NPH; i++) begin : g_ph
    qpc_filter #(.CNT_W(FILT_W)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw[i]),
      .len_i  (filt_len_i),
      .filt_o (filt[i]),
      .vld_o  (vld[i])
    );
  end

  qpc_decode u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .a_i    (filt[0]),
    .b_i    (filt[1]),
    .vld_i  (&vld),
    .busy_i (busy),
    .mode_i (mode_i),
    .evt_o  (evt),
    .up_o   (up),
    .err_o  (err_o)
  );

  qpc_pulse #(.PW_W(PW_W)) u_pls (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .up_i    (up),
    .width_i (pulse_width_i),
    .style_i (style_i),
    .busy_o  (busy),
    .ch0_no  (ch0_no),
    .ch1_o   (ch1_o)
  );
endmodule

// File: rtl/quad_pulse_conv_chk.sv
module quad_pulse_conv_chk #(
  parameter int PW_W = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            style_i,
  input logic [PW_W-1:0] pulse_width_i,
  input logic            ch0_no,
  input logic            ch1_o,
  input logic            err_o
);
  logic            low_any;
  logic [PW_W:0]   run_q;
  logic [PW_W:0]   w_exp;

  assign low_any = style_i ? !ch0_no : (!ch0_no || !ch1_o);
  assign w_exp   = (pulse_width_i == '0) ? (PW_W+1)'(1) : (PW_W+1)'(pulse_width_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= '0;
    else if (low_any) run_q <= run_q + 1'b1;
    else              run_q <= '0;
  end

  // R2
  split_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !style_i |-> !(!ch0_no && !ch1_o));

  // R6
  width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!low_any && run_q != '0) |-> (run_q == w_exp));

  // R9
  dir_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (style_i && $stable(style_i) && !$past(ch0_no)) |-> $stable(ch1_o));

  // R10
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!$fell(ch0_no) && $stable(ch1_o)));
endmodule

bind quad_pulse_conv quad_pulse_conv_chk #(.PW_W(PW_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .style_i       (style_i),
  .pulse_width_i (pulse_width_i),
  .ch0_no        (ch0_no),
  .ch1_o         (ch1_o),
  .err_o         (err_o)
);

// File: tb/tb_quad_pulse_conv.sv
module tb_quad_pulse_conv;
  localparam int FILT_W = 8;
  localparam int PW_W   = 16;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              a_i = 1'b0, b_i = 1'b0;
  logic [1:0]        mode_i = 2'b10;
  logic              style_i = 1'b0;
  logic [FILT_W-1:0] filt_len_i = 8'd3;
  logic [PW_W-1:0]   pulse_width_i = 16'd5;
  logic              ch0_no, ch1_o, err_o;

  int checks = 0, fails = 0;
  int up_cnt = 0, dn_cnt = 0, err_cnt = 0, run = 0, last_w = 0;
  logic p0 = 1'b1, p1 = 1'b1;

  always #2 clk = ~clk;

  quad_pulse_conv #(.FILT_W(FILT_W), .PW_W(PW_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .mode_i(mode_i),
    .style_i(style_i), .filt_len_i(filt_len_i), .pulse_width_i(pulse_width_i),
    .ch0_no(ch0_no), .ch1_o(ch1_o), .err_o(err_o)
  );

  always @(negedge clk) begin
    if (rst_ni) begin
      if (!style_i) begin
        if (p0 && !ch0_no) up_cnt++;
        if (p1 && !ch1_o)  dn_cnt++;
      end else if (!p0 && ch0_no) begin
        if (ch1_o) up_cnt++;
        else       dn_cnt++;
      end
      if (style_i ? !ch0_no : (!ch0_no || !ch1_o)) run++;
      else if (run != 0) begin
        last_w = run;
        run = 0;
      end
      if (err_o) err_cnt++;
    end
    p0 = ch0_no;
    p1 = ch1_o;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input logic [1:0] m, input logic s, input int w);
    @(negedge clk);
    rst_ni = 1'b0;
    mode_i = m;
    style_i = s;
    pulse_width_i = PW_W'(w);
    filt_len_i = 8'd3;
    a_i = 1'b0;
    b_i = 1'b0;
    cyc(3);
    rst_ni = 1'b1;
    cyc(30);
  endtask

  task automatic step(input bit fwd);
    if (fwd) begin
      if (a_i == b_i) a_i = ~a_i; else b_i = ~b_i;
    end else begin
      if (a_i == b_i) b_i = ~b_i; else a_i = ~a_i;
    end
    cyc(20);
  endtask

  task automatic t_reset;
    int u0, d0;
    @(negedge clk);
    rst_ni = 1'b0;
    style_i = 1'b0;
    a_i = 1'b1;
    b_i = 1'b0;
    cyc(3);
    check("R1 ch0 in reset", int'(ch0_no), 1);
    check("R1 ch1 in reset", int'(ch1_o), 1);
    check("R1 err in reset", int'(err_o), 0);
    u0 = up_cnt; d0 = dn_cnt;
    rst_ni = 1'b1;
    cyc(30);
    check("R11 no pulse on first state", (up_cnt - u0) + (dn_cnt - d0), 0);
  endtask

  task automatic t_x4;
    int u0, d0;
    setup(2'b10, 1'b0, 5);
    u0 = up_cnt; d0 = dn_cnt;
    for (int i = 0; i < 8; i++) step(1'b1);
    check("R2 x4 fwd up", up_cnt - u0, 8);
    check("R2 x4 fwd dn", dn_cnt - d0, 0);
    check("R6 width 5", last_w, 5);
    setup(2'b11, 1'b0, 5);
    u0 = up_cnt; d0 = dn_cnt;
    for (int i = 0; i < 8; i++) step(1'b0);
    check("R3 x4 rev dn", dn_cnt - d0, 8);
    check("R3 x4 rev up", up_cnt - u0, 0);
  endtask

  task automatic t_x2;
    int u0, d0;
    setup(2'b01, 1'b0, 5);
    u0 = up_cnt; d0 = dn_cnt;
    for (int i = 0; i < 8; i++) step(1'b1);
    check("R4 x2 fwd up", up_cnt - u0, 4);
    for (int i = 0; i < 8; i++) step(1'b0);
    check("R4 x2 rev dn", dn_cnt - d0, 4);
  endtask

  task automatic t_x1;
    int u0, d0;
    setup(2'b00, 1'b0, 5);
    u0 = up_cnt; d0 = dn_cnt;
    for (int i = 0; i < 8; i++) step(1'b1);
    check("R5 x1 fwd up", up_cnt - u0, 2);
    for (int i = 0; i < 8; i++) step(1'b0);
    check("R5 x1 rev dn", dn_cnt - d0, 2);
    check("R5 x1 fwd no dn", dn_cnt - d0 - 2 + (up_cnt - u0 - 2), 0);
  endtask

  task automatic t_width;
    setup(2'b10, 1'b0, 0);
    step(1'b1);
    check("R6 width 0 as 1", last_w, 1);
    setup(2'b10, 1'b0, 9);
    step(1'b1);
    check("R6 width 9", last_w, 9);
  endtask

  task automatic t_glitch;
    int u0, d0;
    setup(2'b10, 1'b0, 5);
    u0 = up_cnt; d0 = dn_cnt;
    a_i = 1'b1;
    cyc(2);
    a_i = 1'b0;
    cyc(20);
    check("R7 glitch rejected", (up_cnt - u0) + (dn_cnt - d0), 0);
    step(1'b1);
    check("R7 held edge accepted", up_cnt - u0, 1);
  endtask

  task automatic t_inhibit;
    int u0, d0;
    setup(2'b10, 1'b0, 40);
    u0 = up_cnt; d0 = dn_cnt;
    a_i = 1'b1;
    cyc(10);
    b_i = 1'b1;
    cyc(6);
    b_i = 1'b0;
    cyc(70);
    check("R8 dither up", up_cnt - u0, 1);
    check("R8 dither dn", dn_cnt - d0, 0);
  endtask

  task automatic t_comb;
    int u0, d0;
    setup(2'b10, 1'b1, 5);
    check("R9 dir idle up", int'(ch1_o), 1);
    u0 = up_cnt; d0 = dn_cnt;
    for (int i = 0; i < 4; i++) step(1'b1);
    check("R9 comb up", up_cnt - u0, 4);
    for (int i = 0; i < 4; i++) step(1'b0);
    check("R9 comb dn", dn_cnt - d0, 4);
    check("R9 dir held low", int'(ch1_o), 0);
    check("R9 width", last_w, 5);
  endtask

  task automatic t_err;
    int u0, d0, e0;
    setup(2'b10, 1'b0, 5);
    u0 = up_cnt; d0 = dn_cnt; e0 = err_cnt;
    a_i = 1'b1;
    b_i = 1'b1;
    cyc(30);
    check("R10 err once", err_cnt - e0, 1);
    check("R10 no pulse", (up_cnt - u0) + (dn_cnt - d0), 0);
    step(1'b1);
    check("R10 resume up", up_cnt - u0, 1);
  endtask

  initial begin
    t_reset();
    t_x4();
    t_x2();
    t_x1();
    t_width();
    t_glitch();
    t_inhibit();
    t_comb();
    t_err();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule